// File: doc/BRIEF.md
# Board Control and Status Register

This block is one byte-wide register in a local-bus register bank. It gathers board health indications and drives two board-level controls: a board-fail indication and a reset-switch enable. The register sits in byte lane 3 (bits 31..24) of a 32-bit bus word. Software writes through a simple write strobe with byte enables and reads through a read strobe, with data returned one cycle later.

On the hardware side the block takes three synchronous reset sources (power-up, system, local), an external board-fail request, a watchdog timeout, the backplane system-fail level, the system-controller strap and a duplicate reset-switch-enable bit held in a second chip. The board-fail output is active-high. Any pin inversion is done outside the block.

The register mixes several kinds of bit. Two control bits are writable and reload only on the resets listed for them. One bit clears a status when written with 1 and always reads 0. One status bit is sticky and set only by power-up. The rest are live status bits.

Top module: `board_ctl_reg`

## Requirements
- R1: While the power-up reset input is high, the reset-switch bit (bit 24), the board-fail drive bit (bit 25) and the power-up status bit (bit 27) are all set to 1.
- R2: A system or local reset without power-up reset sets bit 25 to 1 and leaves bits 24 and 27 unchanged.
- R3: A write with byte enable 3 high and no reset active loads bit 24 and bit 25 from write data bits 24 and 25.
- R4: A write with byte enable 3 low changes no bit. This includes the status clear action of bit 26.
- R5: A write with byte enable 3 high and write data bit 26 = 1 clears bit 27. Writing 0 to bit 26 leaves bit 27 unchanged. Bit 26 always reads 0.
- R6: The board-fail output is the OR of the external fail input, bit 25 and the watchdog timeout. It updates one clock after its inputs change.
- R7: A watchdog timeout pulse keeps the board-fail output high until the next reset of any kind.
- R8: The reset-switch enable output is the OR of bit 24 and the peer-chip enable input. It updates one clock after either changes.
- R9: Read bit 28 returns the board-fail output level. Bit 29 returns the system-fail level. Bit 30 returns the system-controller strap. Bit 31 and bits 23..0 read 0.
- R10: Read data appears one clock after the read strobe and is all zeros in any cycle that follows a clock with no read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| pwrup_rst_i | input | 1 | Power-up reset, synchronous, active high; implies the other two resets |
| sys_rst_i | input | 1 | System reset, synchronous, active high |
| loc_rst_i | input | 1 | Local reset, synchronous, active high |
| bus_wr_i | input | 1 | Write strobe for this register address |
| bus_rd_i | input | 1 | Read strobe for this register address |
| bus_be_i | input | 4 | Byte enables; bit 3 covers data bits 31..24 |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Registered read data |
| ext_fail_i | input | 1 | Board-fail request from an external device |
| wdog_tmo_i | input | 1 | Watchdog timeout indication |
| sysfail_i | input | 1 | Backplane system-fail level |
| sysctl_strap_i | input | 1 | System-controller strap |
| peer_rsw_en_i | input | 1 | Duplicate reset-switch enable from the second chip |
| brd_fail_o | output | 1 | Board-fail output, active high |
| rsw_en_o | output | 1 | Reset-switch enable |

## Verification
Register bits change on the clock edge that takes a write or a reset. Both outputs follow their inputs one edge later, so a change caused by a write reaches an output two edges after the write. Read data is registered once, so the sampled system-fail and strap values reach a read two edges after the inputs move. The driver holds each stimulus for at least three clocks before a port check. It samples on the falling edge. The monitor compares read data on the falling edge that follows the rising edge which took the read strobe, against the item queued for that read.

// File: rtl/bdctl_pkg.sv
package bdctl_pkg;
  localparam int REG_W  = 8;
  localparam int B_RSW  = 0;
  localparam int B_DRV  = 1;
  localparam int B_CLR  = 2;
  localparam int B_PUS  = 3;
  localparam int B_FAIL = 4;
  localparam int B_SYSF = 5;
  localparam int B_SCON = 6;
  localparam int B_RSV  = 7;

  typedef struct packed {
    logic rsw;
    logic drive;
    logic pu_stat;
  } ctrl_t;
endpackage

// File: rtl/bdctl_ctrl_bits.sv
module bdctl_ctrl_bits
  import bdctl_pkg::*;
(
  input  logic             clk,
  input  logic             pwrup_rst_i,
  input  logic             warm_rst_i,
  input  logic             wr_stb_i,
  input  logic [REG_W-1:0] wr_byte_i,
  output ctrl_t            ctrl_o
);
  ctrl_t ctrl_q;
  logic  wr_ok;
  logic  unused_wr_bits;

  assign wr_ok          = wr_stb_i & ~warm_rst_i;
  assign unused_wr_bits = ^wr_byte_i[REG_W-1:B_PUS];

  always_ff @(posedge clk) begin
    if (pwrup_rst_i) begin
      ctrl_q.rsw     <= 1'b1;
      ctrl_q.drive   <= 1'b1;
      ctrl_q.pu_stat <= 1'b1;
    end else begin
      if (warm_rst_i)
        ctrl_q.drive <= 1'b1;
      else if (wr_ok)
        ctrl_q.drive <= wr_byte_i[B_DRV];
      if (wr_ok)
        ctrl_q.rsw <= wr_byte_i[B_RSW];
      if (wr_ok && wr_byte_i[B_CLR])
        ctrl_q.pu_stat <= 1'b0;
    end
  end

  assign ctrl_o = ctrl_q;
endmodule

// File: rtl/bdctl_fail_path.sv
module bdctl_fail_path (
  input  logic clk,
  input  logic any_rst_i,
  input  logic ext_fail_i,
  input  logic wdog_tmo_i,
  input  logic sysfail_i,
  input  logic strap_i,
  input  logic peer_en_i,
  input  logic drive_i,
  input  logic rsw_i,
  output logic fail_o,
  output logic rsw_en_o,
  output logic sysf_o,
  output logic scon_o
);
  logic wd_hold_q;
  logic fail_q;
  logic rsw_en_q;
  logic sysf_q;
  logic scon_q;

  always_ff @(posedge clk) begin
    if (any_rst_i)
      wd_hold_q <= 1'b0;
    else if (wdog_tmo_i)
      wd_hold_q <= 1'b1;
  end

  always_ff @(posedge clk) begin
    fail_q   <= ext_fail_i | drive_i | wd_hold_q | wdog_tmo_i;
    rsw_en_q <= rsw_i | peer_en_i;
    sysf_q   <= sysfail_i;
    scon_q   <= strap_i;
  end

  assign fail_o   = fail_q;
  assign rsw_en_o = rsw_en_q;
  assign sysf_o   = sysf_q;
  assign scon_o   = scon_q;
endmodule

// File: rtl/bdctl_readback.sv
module bdctl_readback
  import bdctl_pkg::*;
#(
  parameter int BUS_W = 32,
  parameter int LANE  = 3
) (
  input  logic             clk,
  input  logic             rd_i,
  input  ctrl_t            ctrl_i,
  input  logic             fail_i,
  input  logic             sysf_i,
  input  logic             scon_i,
  output logic [BUS_W-1:0] rdata_o
);
  localparam int LO = LANE * REG_W;

  logic [REG_W-1:0] img_byte;
  logic [BUS_W-1:0] img_word;
  logic [BUS_W-1:0] rdata_q;

  always_comb begin
    img_byte         = '0;
    img_byte[B_RSW]  = ctrl_i.rsw;
    img_byte[B_DRV]  = ctrl_i.drive;
    img_byte[B_CLR]  = 1'b0;
    img_byte[B_PUS]  = ctrl_i.pu_stat;
    img_byte[B_FAIL] = fail_i;
    img_byte[B_SYSF] = sysf_i;
    img_byte[B_SCON] = scon_i;
    img_byte[B_RSV]  = 1'b0;
    img_word              = '0;
    img_word[LO +: REG_W] = img_byte;
  end

  always_ff @(posedge clk) begin
    if (rd_i) rdata_q <= img_word;
    else      rdata_q <= '0;
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/board_ctl_reg.sv
module board_ctl_reg
  import bdctl_pkg::*;
#(
  parameter int BUS_W = 32,
  parameter int LANE  = 3,
  localparam int BE_W = BUS_W / 8,
  localparam int LO   = LANE * REG_W
) (
  input  logic             clk,
  input  logic             pwrup_rst_i,
  input  logic             sys_rst_i,
  input  logic             loc_rst_i,
  input  logic             bus_wr_i,
  input  logic             bus_rd_i,
  input  logic [BE_W-1:0]  bus_be_i,
  input  logic [BUS_W-1:0] bus_wdata_i,
  output logic [BUS_W-1:0] bus_rdata_o,
  input  logic             ext_fail_i,
  input  logic             wdog_tmo_i,
  input  logic             sysfail_i,
  input  logic             sysctl_strap_i,
  input  logic             peer_rsw_en_i,
  output logic             brd_fail_o,
  output logic             rsw_en_o
);
  ctrl_t ctrl_q;
  logic  warm_rst;
  logic  any_rst;
  logic  lane_wr;
  logic  sysf_s;
  logic  scon_s;
  logic  unused_bus;

  assign warm_rst   = sys_rst_i | loc_rst_i;
  assign any_rst    = pwrup_rst_i | warm_rst;
  assign lane_wr    = bus_wr_i & bus_be_i[LANE];
  assign unused_bus = ^{bus_wdata_i, bus_be_i};

  bdctl_ctrl_bits u_bits (
    .clk         (clk),
    .pwrup_rst_i (pwrup_rst_i),
    .warm_rst_i  (warm_rst),
    .wr_stb_i    (lane_wr),
    .wr_byte_i   (bus_wdata_i[LO +: REG_W]),
    .ctrl_o      (ctrl_q)
  );

  bdctl_fail_path u_fail (
    .clk        (clk),
    .any_rst_i  (any_rst),
    .ext_fail_i (ext_fail_i),
    .wdog_tmo_i (wdog_tmo_i),
    .sysfail_i  (sysfail_i),
    .strap_i    (sysctl_strap_i),
    .peer_en_i  (peer_rsw_en_i),
    .drive_i    (ctrl_q.drive),
    .rsw_i      (ctrl_q.rsw),
    .fail_o     (brd_fail_o),
    .rsw_en_o   (rsw_en_o),
    .sysf_o     (sysf_s),
    .scon_o     (scon_s)
  );

  bdctl_readback #(.BUS_W(BUS_W), .LANE(LANE)) u_rd (
    .clk     (clk),
    .rd_i    (bus_rd_i),
    .ctrl_i  (ctrl_q),
    .fail_i  (brd_fail_o),
    .sysf_i  (sysf_s),
    .scon_i  (scon_s),
    .rdata_o (bus_rdata_o)
  );
endmodule

// File: rtl/bdctl_chk.sv
module bdctl_chk #(
  parameter int BUS_W = 32,
  parameter int LANE  = 3
) (
  input logic             clk,
  input logic             pwrup_rst_i,
  input logic             sys_rst_i,
  input logic             loc_rst_i,
  input logic             bus_wr_i,
  input logic             bus_rd_i,
  input logic [3:0]       bus_be_i,
  input logic [BUS_W-1:0] bus_rdata_o,
  input logic             ext_fail_i,
  input logic             wdog_tmo_i,
  input logic             peer_rsw_en_i,
  input logic             brd_fail_o,
  input logic             rsw_en_o,
  input logic             st_rsw,
  input logic             st_drive,
  input logic             st_pus
);
  logic any_rst;
  logic wd_seen_q;
  assign any_rst = pwrup_rst_i | sys_rst_i | loc_rst_i;

  always_ff @(posedge clk) begin
    if (any_rst)         wd_seen_q <= 1'b0;
    else if (wdog_tmo_i) wd_seen_q <= 1'b1;
  end

  a_r1_pwrup_load: assert property (@(posedge clk)
    pwrup_rst_i |=> (st_rsw && st_drive && st_pus));

  a_r2_warm_keeps: assert property (@(posedge clk) disable iff (pwrup_rst_i)
    (sys_rst_i || loc_rst_i) |=> ($stable(st_rsw) && $stable(st_pus) && st_drive));

  a_r4_lane_off: assert property (@(posedge clk) disable iff (any_rst)
    (bus_wr_i && !bus_be_i[LANE]) |=> ($stable(st_rsw) && $stable(st_drive) && $stable(st_pus)));

  a_r5_clr_reads_zero: assert property (@(posedge clk)
    !bus_rdata_o[LANE*8+2]);

  a_r6_fail_or: assert property (@(posedge clk) disable iff (any_rst)
    (ext_fail_i || wdog_tmo_i || st_drive) |=> brd_fail_o);

  a_r7_wdog_hold: assert property (@(posedge clk) disable iff (any_rst)
    wd_seen_q |=> brd_fail_o);

  a_r8_rsw_or: assert property (@(posedge clk) disable iff (any_rst)
    (peer_rsw_en_i || st_rsw) |=> rsw_en_o);

  a_r9_unused_zero: assert property (@(posedge clk)
    (!bus_rdata_o[BUS_W-1] && bus_rdata_o[LANE*8-1:0] == '0));

  a_r10_idle_zero: assert property (@(posedge clk) disable iff (pwrup_rst_i)
    !bus_rd_i |=> (bus_rdata_o == '0));
endmodule

bind board_ctl_reg bdctl_chk #(.BUS_W(BUS_W), .LANE(LANE)) u_chk (
  .clk           (clk),
  .pwrup_rst_i   (pwrup_rst_i),
  .sys_rst_i     (sys_rst_i),
  .loc_rst_i     (loc_rst_i),
  .bus_wr_i      (bus_wr_i),
  .bus_rd_i      (bus_rd_i),
  .bus_be_i      (bus_be_i),
  .bus_rdata_o   (bus_rdata_o),
  .ext_fail_i    (ext_fail_i),
  .wdog_tmo_i    (wdog_tmo_i),
  .peer_rsw_en_i (peer_rsw_en_i),
  .brd_fail_o    (brd_fail_o),
  .rsw_en_o      (rsw_en_o),
  .st_rsw        (ctrl_q.rsw),
  .st_drive      (ctrl_q.drive),
  .st_pus        (ctrl_q.pu_stat)
);

// File: tb/board_ctl_reg_test.sv
`timescale 1ns/1ps
module board_ctl_reg_test;
  logic        clk = 1'b0;
  logic        pwrup_rst = 1'b1, sys_rst = 1'b0, loc_rst = 1'b0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [3:0]  be = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        ext_fail = 1'b0, wdog = 1'b0, sysfail = 1'b0, strap = 1'b1, peer = 1'b0;
  logic        fail_o, rsw_o;

  int n_chk = 0, n_fail = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic        rd_seen = 1'b0;
  logic        done = 1'b0;

  always #4 clk = ~clk;

  board_ctl_reg uut (
    .clk(clk), .pwrup_rst_i(pwrup_rst), .sys_rst_i(sys_rst), .loc_rst_i(loc_rst),
    .bus_wr_i(wr), .bus_rd_i(rd), .bus_be_i(be), .bus_wdata_i(wdata),
    .bus_rdata_o(rdata), .ext_fail_i(ext_fail), .wdog_tmo_i(wdog),
    .sysfail_i(sysfail), .sysctl_strap_i(strap), .peer_rsw_en_i(peer),
    .brd_fail_o(fail_o), .rsw_en_o(rsw_o)
  );

  function automatic logic [31:0] img(input logic scon, sysf, fl, pus, drv, rsw);
    return {1'b0, scon, sysf, fl, pus, 1'b0, drv, rsw, 24'h0};
  endfunction

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_write(input logic [3:0] en, input logic [31:0] d);
    @(negedge clk);
    wr = 1'b1; be = en; wdata = d;
    @(negedge clk);
    wr = 1'b0; be = '0; wdata = '0;
  endtask

  task automatic bus_read(input logic [31:0] exp, input string req);
    @(negedge clk);
    exp_q.push_back(exp); tag_q.push_back(req);
    rd = 1'b1;
    @(negedge clk);
    rd = 1'b0;
    @(negedge clk);
  endtask

  task automatic pulse(ref logic sig);
    @(negedge clk); sig = 1'b1;
    @(negedge clk); sig = 1'b0;
  endtask

  always @(posedge clk) rd_seen <= rd;

  always @(negedge clk) begin
    if (rd_seen) begin
      if (exp_q.size() == 0) begin
        n_chk++; n_fail++;
        $display("FAIL R10: unexpected read data %h expected none", rdata);
      end else begin
        chk(rdata, exp_q.pop_front(), tag_q.pop_front());
      end
    end
  end

  initial begin
    tick(4);
    pwrup_rst = 1'b0;
    tick(3);
    chk({31'h0, fail_o}, 32'h1, "R1 fail out after power-up");
    chk({31'h0, rsw_o},  32'h1, "R1 switch enable after power-up");
    chk(rdata, 32'h0, "R10 idle read data");
    bus_read(img(1,0,1,1,1,1), "R1 R9 image after power-up");

    bus_write(4'b1000, 32'h0000_0000);
    tick(3);
    chk({31'h0, fail_o}, 32'h0, "R6 fail out with all sources low");
    chk({31'h0, rsw_o},  32'h0, "R8 switch enable with both low");
    bus_read(img(1,0,0,1,0,0), "R3 R5 bits cleared, status kept");

    bus_write(4'b0111, 32'hFFFF_FFFF);
    tick(3);
    bus_read(img(1,0,0,1,0,0), "R4 lane off write ignored");
    chk({31'h0, fail_o}, 32'h0, "R4 fail out unchanged");

    peer = 1'b1; tick(3);
    chk({31'h0, rsw_o}, 32'h1, "R8 peer enable alone");
    peer = 1'b0; tick(3);
    chk({31'h0, rsw_o}, 32'h0, "R8 peer released");

    ext_fail = 1'b1; tick(3);
    chk({31'h0, fail_o}, 32'h1, "R6 external fail");
    bus_read(img(1,0,1,1,0,0), "R9 bit 28 follows fail out");
    ext_fail = 1'b0; tick(3);
    chk({31'h0, fail_o}, 32'h0, "R6 external fail released");

    sysfail = 1'b1; strap = 1'b0; tick(3);
    bus_read(img(0,1,0,1,0,0), "R9 system-fail and strap");
    sysfail = 1'b0; strap = 1'b1; tick(3);

    bus_write(4'b1000, 32'h0400_0000);
    tick(3);
    bus_read(img(1,0,0,0,0,0), "R5 status cleared, bit 26 reads 0");

    bus_write(4'b1000, 32'h0300_0000);
    tick(3);
    chk({31'h0, fail_o}, 32'h1, "R6 drive bit");
    chk({31'h0, rsw_o},  32'h1, "R3 switch bit drives enable");
    bus_write(4'b1000, 32'h0100_0000);
    tick(3);

    pulse(sys_rst); tick(3);
    bus_read(img(1,0,1,0,1,1), "R2 system reset");
    bus_write(4'b1000, 32'h0000_0000);
    tick(3);
    pulse(loc_rst); tick(3);
    bus_read(img(1,0,1,0,1,0), "R2 local reset");
    bus_write(4'b1000, 32'h0000_0000);
    tick(3);
    chk({31'h0, fail_o}, 32'h0, "R6 fail low before watchdog");

    pulse(wdog); tick(2);
    chk({31'h0, fail_o}, 32'h1, "R7 watchdog raises fail");
    tick(6);
    chk({31'h0, fail_o}, 32'h1, "R7 watchdog held");
    pulse(loc_rst); tick(2);
    bus_write(4'b1000, 32'h0000_0000);
    tick(3);
    chk({31'h0, fail_o}, 32'h0, "R7 reset releases watchdog hold");

    pulse(pwrup_rst); tick(3);
    bus_read(img(1,0,1,1,1,1), "R1 second power-up");
    chk(rdata, 32'h0, "R10 idle after read");

    tick(2);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule